// File: doc/BRIEF.md
# Fractional Master and Serial Clock Divider Chain

This block derives two slow timing references from a fast source. One source tick stream is picked from three candidates: an external crystal tick or one of two internal PLL ticks. All three arrive as single-cycle enables in the block's own clock domain. The picked stream goes through a pre-divider with ratios of 2, 2.5 or 3, or an off setting. An integer divide-by-N stage follows it and produces the master clock. The serial clock comes from the master clock through a final stage that divides by 2 or by 4.

Each clock is delivered in two forms. The first is a one-cycle enable pulse for logic that runs on the fast clock. The second is a level that flips on every pulse and so looks like a clock. The configuration inputs are sampled on every cycle. Any change to them restarts the whole chain from zero, so a reprogrammed ratio never produces a shortened first period.

Top module: `mcd_clock_chain`

## Requirements
- R1: While rst_n is low, and on the first cycle after rst_n goes high, mclk_tick, sclk_tick, mclk_out and sclk_out are all 0.
- R2: While master_en is 0, no mclk_tick or sclk_tick pulse appears and both toggled outputs stay at 0, whatever the other inputs do.
- R3: pre_sel = 2'b00 stops the chain: there are no pulses and the toggled outputs stay at 0.
- R4: use_pll = 0 selects xtal_tick. use_pll = 1 selects pll2_tick when pll_pick = 1 and pll1_tick when pll_pick = 0. Ticks on the sources that are not selected have no effect. An output pulse appears only on the cycle after a selected source tick.
- R5: pre_sel = 2'b01 divides by 2, emitting a pre-divided pulse on every 2nd selected tick counted from a restart. pre_sel = 2'b11 divides by 3, emitting one on every 3rd.
- R6: pre_sel = 2'b10 divides by 2.5. Within each group of 5 selected ticks counted from a restart, pre-divided pulses fall on the 2nd and 5th ticks, so the gaps alternate 3, 2, 3, 2 source ticks.
- R7: The N stage emits mclk_tick on every N-th pre-divided pulse, where N is mdiv. An mdiv value of 0 or 1 passes every pre-divided pulse through.
- R8: sclk_tick fires on every 4th mclk_tick when sclk_quarter = 1 and on every 2nd when it is 0. It always coincides with an mclk_tick.
- R9: mclk_out and sclk_out flip on every cycle where mclk_tick or sclk_tick, respectively, is 1. A restart forces both to 0.
- R10: A change in any configuration input (master_en, use_pll, pll_pick, pre_sel, mdiv, sclk_quarter) clears every stage. The next cycle carries no pulse, and counting starts afresh from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock of the block's domain |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | External crystal source enable |
| pll1_tick | input | 1 | First internal PLL source enable |
| pll2_tick | input | 1 | Second internal PLL source enable |
| master_en | input | 1 | Master clock generation enable |
| use_pll | input | 1 | 0: crystal, 1: internal PLL |
| pll_pick | input | 1 | 0: PLL one, 1: PLL two |
| pre_sel | input | 2 | Pre-divider: 00 off, 01 /2, 10 /2.5, 11 /3 |
| mdiv | input | MDIV_W | Integer master divisor N (0 and 1 mean 1) |
| sclk_quarter | input | 1 | 1: serial clock is master/4, 0: master/2 |
| mclk_tick | output | 1 | One-cycle master clock enable |
| sclk_tick | output | 1 | One-cycle serial clock enable |
| mclk_out | output | 1 | Master clock level, flips per pulse |
| sclk_out | output | 1 | Serial clock level, flips per pulse |

## Verification
Each programmed setting is measured by counting output pulses over a long window in which all three sources tick at random, at different densities. Because each source has its own density, choosing the wrong source produces a count that differs from the one expected for the selected source. Randomly chosen legal settings test the product of the three divisors. Directed settings cover the corners: divisors 0, 1 and the maximum, the off and disabled settings, and the exact 3-2 gap pattern of the 2.5 mode under a continuous source. A reprogramming case moves the counters partway through a period and then changes to a new setting. It tells a true restart apart from counting that carries over, because carried-over state would produce a count that does not match one computed from zero.

// File: rtl/mcd_pkg.sv
// Shared types for the clock divider chain.
// Assumes: pre-divider encoding is fixed by the configuration field.
package mcd_pkg;

    typedef enum logic [1:0] {
        PRE_OFF    = 2'b00,
        PRE_DIV2   = 2'b01,
        PRE_DIV2P5 = 2'b10,
        PRE_DIV3   = 2'b11
    } pre_mode_e;

    // Pre-divider counter width: covers the longest cycle (5 ticks).
    localparam int PRE_CNT_W = 3;

endpackage

// File: rtl/mcd_src_mux.sv
// Source selector: picks one of three tick enables.
// Assumes: all sources are single-cycle enables in the clk domain.
module mcd_src_mux (
    input  logic xtal_tick,
    input  logic pll1_tick,
    input  logic pll2_tick,
    input  logic use_pll,
    input  logic pll_pick,
    output logic src_tick
);

    // Select crystal, or one of the PLLs when the internal source is chosen.
    always_comb begin
        if (!use_pll)
            src_tick = xtal_tick;
        else if (pll_pick)
            src_tick = pll2_tick;
        else
            src_tick = pll1_tick;
    end

endmodule

// File: rtl/mcd_pre_div.sv
// Pre-divider: divides the source tick stream by 2, 2.5 or 3.
// The 2.5 ratio fires on the 2nd and 5th tick of each group of five.
// Assumes: clear is raised for the off mode and on any reprogramming.
module mcd_pre_div
    import mcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      tick_in,
    input  pre_mode_e mode,
    output logic      tick_out
);

    logic [PRE_CNT_W-1:0] cnt;
    logic [PRE_CNT_W-1:0] last;
    logic                 fire;

    // Decode the wrap point and firing positions for the active mode.
    always_comb begin
        unique case (mode)
            PRE_DIV2: begin
                last = PRE_CNT_W'(1);
                fire = (cnt == PRE_CNT_W'(1));
            end
            PRE_DIV2P5: begin
                last = PRE_CNT_W'(4);
                fire = (cnt == PRE_CNT_W'(1)) || (cnt == PRE_CNT_W'(4));
            end
            PRE_DIV3: begin
                last = PRE_CNT_W'(2);
                fire = (cnt == PRE_CNT_W'(2));
            end
            default: begin
                last = '0;
                fire = 1'b0;
            end
        endcase
    end

    assign tick_out = tick_in && fire && !clear;

    // Advance the position counter on each source tick, wrapping at the mode limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick_in)
            cnt <= (cnt == last) ? '0 : cnt + PRE_CNT_W'(1);
    end

endmodule

// File: rtl/mcd_mod_counter.sv
// Modulo counter stage: passes every (limit+1)-th input tick.
// Assumes: limit is held stable between clears.
module mcd_mod_counter #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] limit,
    output logic             tick_out
);

    logic [CNT_W-1:0] cnt;

    assign tick_out = tick_in && (cnt == limit) && !clear;

    // Count input ticks and wrap at the programmed terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (tick_in)
            cnt <= (cnt == limit) ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/mcd_clock_chain.sv
// Top of the divider chain: source select, fractional pre-divide,
// integer N divide for the master clock, /2 or /4 for the serial clock.
// Outputs are registered, so they appear one cycle after the source tick.
// Assumes: configuration inputs come from a register in the same domain.
module mcd_clock_chain
    import mcd_pkg::*;
#(
    parameter int MDIV_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_tick,
    input  logic              pll1_tick,
    input  logic              pll2_tick,
    input  logic              master_en,
    input  logic              use_pll,
    input  logic              pll_pick,
    input  logic [1:0]        pre_sel,
    input  logic [MDIV_W-1:0] mdiv,
    input  logic              sclk_quarter,
    output logic              mclk_tick,
    output logic              sclk_tick,
    output logic              mclk_out,
    output logic              sclk_out
);

    localparam int CFG_W   = MDIV_W + 6;
    localparam int SDIV_W  = 2;
    localparam int N_OUTS  = 2;

    logic [CFG_W-1:0]  cfg_now;
    logic [CFG_W-1:0]  cfg_q;
    logic              cfg_changed;
    logic              running;
    logic              clear;
    logic              src_tick;
    logic              pre_tick;
    logic              mclk_pulse;
    logic              sclk_pulse;
    logic [MDIV_W-1:0] n_limit;
    logic [SDIV_W-1:0] s_limit;
    logic [N_OUTS-1:0] pulse;
    logic [N_OUTS-1:0] tick_q;
    logic [N_OUTS-1:0] tog_q;

    assign cfg_now     = {master_en, use_pll, pll_pick, pre_sel, mdiv, sclk_quarter};
    assign cfg_changed = (cfg_now != cfg_q);
    assign running     = master_en && (pre_mode_e'(pre_sel) != PRE_OFF);
    assign clear       = cfg_changed || !running;

    // Remember the last configuration to detect reprogramming.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else
            cfg_q <= cfg_now;
    end

    // Map the divisor fields onto terminal counts.
    always_comb begin
        n_limit = (mdiv <= MDIV_W'(1)) ? '0 : mdiv - MDIV_W'(1);
        s_limit = sclk_quarter ? SDIV_W'(3) : SDIV_W'(1);
    end

    mcd_src_mux u_src (
        .xtal_tick (xtal_tick),
        .pll1_tick (pll1_tick),
        .pll2_tick (pll2_tick),
        .use_pll   (use_pll),
        .pll_pick  (pll_pick),
        .src_tick  (src_tick)
    );

    mcd_pre_div u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .tick_in  (src_tick),
        .mode     (pre_mode_e'(pre_sel)),
        .tick_out (pre_tick)
    );

    mcd_mod_counter #(.CNT_W(MDIV_W)) u_ndiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .tick_in  (pre_tick),
        .limit    (n_limit),
        .tick_out (mclk_pulse)
    );

    mcd_mod_counter #(.CNT_W(SDIV_W)) u_sdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .tick_in  (mclk_pulse),
        .limit    (s_limit),
        .tick_out (sclk_pulse)
    );

    assign pulse = {sclk_pulse, mclk_pulse};

    // One registered pulse and one toggled level per output clock.
    for (genvar i = 0; i < N_OUTS; i++) begin : g_out
        logic tick_r;
        logic tog_r;

        // Register the pulse and flip the level on each pulse; restart forces low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tick_r <= 1'b0;
                tog_r  <= 1'b0;
            end else if (clear) begin
                tick_r <= 1'b0;
                tog_r  <= 1'b0;
            end else begin
                tick_r <= pulse[i];
                if (pulse[i])
                    tog_r <= ~tog_r;
            end
        end

        assign tick_q[i] = tick_r;
        assign tog_q[i]  = tog_r;
    end

    assign mclk_tick = tick_q[0];
    assign sclk_tick = tick_q[1];
    assign mclk_out  = tog_q[0];
    assign sclk_out  = tog_q[1];

endmodule

// File: rtl/mcd_clock_chain_chk.sv
// Checker for the divider chain, attached to the top by bind.
// Observes ports only.
module mcd_clock_chain_chk #(
    parameter int MDIV_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xtal_tick,
    input logic              pll1_tick,
    input logic              pll2_tick,
    input logic              master_en,
    input logic              use_pll,
    input logic              pll_pick,
    input logic [1:0]        pre_sel,
    input logic [MDIV_W-1:0] mdiv,
    input logic              sclk_quarter,
    input logic              mclk_tick,
    input logic              sclk_tick,
    input logic              mclk_out,
    input logic              sclk_out
);

    logic              sel_src;
    logic [MDIV_W+5:0] cfg_word;

    assign sel_src  = use_pll ? (pll_pick ? pll2_tick : pll1_tick) : xtal_tick;
    assign cfg_word = {master_en, use_pll, pll_pick, pre_sel, mdiv, sclk_quarter};

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mclk_tick && !sclk_tick && !mclk_out && !sclk_out));

    p_master_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!mclk_tick && !sclk_tick && !mclk_out && !sclk_out));

    p_pre_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_sel == 2'b00) |=> (!mclk_tick && !sclk_tick && !mclk_out));

    p_tick_needs_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_src |=> !mclk_tick);

    p_sclk_on_mclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |-> mclk_tick);

    p_mclk_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_tick |-> (mclk_out != $past(mclk_out)));

    p_sclk_flips_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |-> (sclk_out != $past(sclk_out)));

    p_change_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (cfg_word != $past(cfg_word))) |=> (!mclk_tick && !mclk_out && !sclk_out));

endmodule

bind mcd_clock_chain mcd_clock_chain_chk #(.MDIV_W(MDIV_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xtal_tick    (xtal_tick),
    .pll1_tick    (pll1_tick),
    .pll2_tick    (pll2_tick),
    .master_en    (master_en),
    .use_pll      (use_pll),
    .pll_pick     (pll_pick),
    .pre_sel      (pre_sel),
    .mdiv         (mdiv),
    .sclk_quarter (sclk_quarter),
    .mclk_tick    (mclk_tick),
    .sclk_tick    (sclk_tick),
    .mclk_out     (mclk_out),
    .sclk_out     (sclk_out)
);

// File: tb/mcd_clock_chain_test.sv
`timescale 1ns/1ps
module mcd_clock_chain_test;

    localparam int MDIV_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xtal_tick = 1'b0;
    logic              pll1_tick = 1'b0;
    logic              pll2_tick = 1'b0;
    logic              master_en = 1'b0;
    logic              use_pll = 1'b0;
    logic              pll_pick = 1'b0;
    logic [1:0]        pre_sel = 2'b00;
    logic [MDIV_W-1:0] mdiv = '0;
    logic              sclk_quarter = 1'b0;
    logic              mclk_tick;
    logic              sclk_tick;
    logic              mclk_out;
    logic              sclk_out;

    int checks = 0;
    int failures = 0;
    int m_cnt, s_cnt, stray, src_cnt;

    mcd_clock_chain #(.MDIV_W(MDIV_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .xtal_tick(xtal_tick), .pll1_tick(pll1_tick), .pll2_tick(pll2_tick),
        .master_en(master_en), .use_pll(use_pll), .pll_pick(pll_pick),
        .pre_sel(pre_sel), .mdiv(mdiv), .sclk_quarter(sclk_quarter),
        .mclk_tick(mclk_tick), .sclk_tick(sclk_tick),
        .mclk_out(mclk_out), .sclk_out(sclk_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pre-divided pulses after s ticks counted from a restart (R5, R6).
    function automatic int exp_pre(input logic [1:0] sel, input int s);
        case (sel)
            2'b01:   return s / 2;
            2'b10:   return 2 * (s / 5) + (((s % 5) >= 2) ? 1 : 0);
            2'b11:   return s / 3;
            default: return 0;
        endcase
    endfunction

    function automatic int eff_n(input int n);
        return (n <= 1) ? 1 : n;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            xtal_tick = 1'b0; pll1_tick = 1'b0; pll2_tick = 1'b0;
        end
    endtask

    task automatic set_cfg(input bit me, input bit up, input bit pp,
                           input logic [1:0] ps, input int md, input bit sq);
        @(negedge clk);
        xtal_tick = 1'b0; pll1_tick = 1'b0; pll2_tick = 1'b0;
        master_en = me; use_pll = up; pll_pick = pp;
        pre_sel = ps; mdiv = MDIV_W'(md); sclk_quarter = sq;
    endtask

    // Drive random ticks on all sources with distinct densities; count outputs.
    task automatic run_window(input int cycles);
        m_cnt = 0; s_cnt = 0; stray = 0; src_cnt = 0;
        for (int i = 0; i < cycles + 3; i++) begin
            @(negedge clk);
            if (mclk_tick) m_cnt++;
            if (sclk_tick) s_cnt++;
            if (sclk_tick && !mclk_tick) stray++;
            if (i < cycles) begin
                xtal_tick = (($urandom % 100) < 60);
                pll1_tick = (($urandom % 100) < 35);
                pll2_tick = (($urandom % 100) < 80);
                if (!use_pll ? xtal_tick : (pll_pick ? pll2_tick : pll1_tick)) src_cnt++;
            end else begin
                xtal_tick = 1'b0; pll1_tick = 1'b0; pll2_tick = 1'b0;
            end
        end
    endtask

    task automatic measure(input bit me, input bit up, input bit pp, input logic [1:0] ps,
                           input int md, input bit sq, input int cycles,
                           input bit restart_via_off, input string tag);
        int p, m, s;
        if (restart_via_off) begin
            set_cfg(1'b0, up, pp, ps, md, sq);
            idle(2);
        end
        set_cfg(me, up, pp, ps, md, sq);
        idle(2);
        check(!mclk_out && !sclk_out, {tag, " R9 levels low after restart"}, int'(mclk_out), 0);
        run_window(cycles);
        p = me ? exp_pre(ps, src_cnt) : 0;
        m = p / eff_n(md);
        s = m / (sq ? 4 : 2);
        check(m_cnt == m, {tag, " mclk pulse count"}, m_cnt, m);
        check(s_cnt == s, {tag, " R8 sclk pulse count"}, s_cnt, s);
        check(stray == 0, {tag, " R8 sclk without mclk"}, stray, 0);
        check(mclk_out == m[0], {tag, " R9 mclk level parity"}, int'(mclk_out), m % 2);
        check(sclk_out == s[0], {tag, " R9 sclk level parity"}, int'(sclk_out), s % 2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int pos[4];
        int found;
        int t;
        void'($urandom(32'h00C0FFEE));

        // R1: reset state
        master_en = 1'b1; pre_sel = 2'b01; xtal_tick = 1'b1;
        repeat (4) @(negedge clk);
        check(!mclk_tick && !sclk_tick && !mclk_out && !sclk_out, "R1 outputs during reset",
              int'({mclk_tick, sclk_tick, mclk_out, sclk_out}), 0);
        master_en = 1'b0; pre_sel = 2'b00; xtal_tick = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mclk_tick && !sclk_tick && !mclk_out && !sclk_out, "R1 outputs after release",
              int'({mclk_tick, sclk_tick, mclk_out, sclk_out}), 0);

        // R2: master disabled with a live pre-divider
        measure(1'b0, 1'b0, 1'b0, 2'b01, 1, 1'b0, 300, 1'b1, "R2 master off");
        // R3: pre-divider off
        measure(1'b1, 1'b0, 1'b0, 2'b00, 1, 1'b0, 300, 1'b1, "R3 pre off");
        // R4 R5: crystal /2, N pass-through
        measure(1'b1, 1'b0, 1'b1, 2'b01, 1, 1'b0, 800, 1'b1, "R4 R5 xtal div2");
        // R4 R5 R7: PLL one /3, mdiv 0
        measure(1'b1, 1'b1, 1'b0, 2'b11, 0, 1'b1, 800, 1'b1, "R4 R5 R7 pll1 div3 n0");
        // R4 R6: PLL two /2.5
        measure(1'b1, 1'b1, 1'b1, 2'b10, 1, 1'b0, 800, 1'b1, "R4 R6 pll2 div2p5");
        // R7: largest N with /3 and /4
        measure(1'b1, 1'b0, 1'b0, 2'b11, 127, 1'b1, 4000, 1'b1, "R7 max n");

        // R6: gap pattern 3,2,3 under a continuous crystal source
        set_cfg(1'b1, 1'b0, 1'b0, 2'b10, 1, 1'b0);
        idle(2);
        found = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mclk_tick && found < 4) begin pos[found] = i; found++; end
            xtal_tick = 1'b1;
        end
        idle(2);
        check(found == 4, "R6 pulses seen", found, 4);
        if (found == 4) begin
            check(pos[1] - pos[0] == 3, "R6 first gap", pos[1] - pos[0], 3);
            check(pos[2] - pos[1] == 2, "R6 second gap", pos[2] - pos[1], 2);
            check(pos[3] - pos[2] == 3, "R6 third gap", pos[3] - pos[2], 3);
        end

        // R10: advance counters part-way, then reprogram directly
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01, 5, 1'b1);
        idle(1);
        run_window(37);
        measure(1'b1, 1'b0, 1'b0, 2'b11, 2, 1'b0, 600, 1'b0, "R10 reprogram");
        set_cfg(1'b1, 1'b0, 1'b0, 2'b01, 3, 1'b0);
        idle(1);
        run_window(41);
        measure(1'b1, 1'b1, 1'b1, 2'b10, 3, 1'b1, 600, 1'b0, "R10 reprogram 2p5");

        // Random legal settings: ratio against the product of divisors (R4 R5 R6 R7 R8)
        for (int k = 0; k < 25; k++) begin
            logic [1:0] ps;
            ps = 2'(1 + ($urandom % 3));
            t = $urandom % 10;
            measure(1'b1, 1'($urandom % 2), 1'($urandom % 2), ps, t,
                    1'($urandom % 2), 800, 1'($urandom % 2), "R7 random setting");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule